// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one shift register that holds the outcomes of the most recent conditional branches. Every branch in the program feeds this register, so there is no separate history per branch. The history is combined by XOR with word-address bits of the branch address. The result selects one entry in a shared table of 2-bit saturating counters. Because the address is part of the hash, two branches that see the same history pattern usually train different entries.

A lookup is combinational. The front end places a branch address on the predict port and gets back a direction bit in the same cycle. It also gets the table index that was used. The front end carries that index with the branch. When the branch resolves, it returns the index together with the real outcome on the update port. On the next rising edge, the counter at that index is trained and the outcome is shifted into the history.

Top module: `gshare_predictor`

## Requirements
- R1: After synchronous reset, every counter holds 1, so every lookup predicts not-taken. The history is zero, so `pred_index` equals address bits [HIST_LEN+1:2].
- R2: `pred_index` equals the history XOR `pred_pc[HIST_LEN+1:2]`. Address bits [1:0] and the bits above HIST_LEN+1 have no effect on it.
- R3: A taken update increments the addressed counter, and a counter at 3 stays at 3.
- R4: A not-taken update decrements the addressed counter, and a counter at 0 stays at 0.
- R5: `pred_taken` is 1 exactly when the selected counter holds 2 or 3.
- R6: An update shifts `upd_taken` into history bit 0, moves the other bits up by one, and drops the oldest bit.
- R7: If a lookup and an update hit the same entry in one cycle, the lookup returns the counter value from before the update.
- R8: While `upd_valid` is 0, the `upd_index` and `upd_taken` inputs change neither the counters nor the history.
- R9: An update changes only the counter at `upd_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 means taken |
| pred_index | output | HIST_LEN | Table index used for this lookup, to be returned with the update |
| upd_valid | input | 1 | Qualifies an update in this cycle |
| upd_index | input | HIST_LEN | Index captured when the resolved branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 means taken |

## Verification
Lookup and training can occur in the same cycle, and they can target the same counter. The bench provokes this by holding an address whose hashed index equals `upd_index` while `upd_valid` is high. It samples `pred_taken` before the edge and expects the old counter direction. After the edge, it looks up the same entry again under the shifted history and expects the trained value. A bench-side model of every counter and of the history judges both samples, and the same model checks all entries after long pseudo-random training runs.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] sat2_t;

  localparam sat2_t SAT_RESET = 2'd1;
  localparam sat2_t SAT_MAX   = 2'd3;
  localparam sat2_t SAT_MIN   = 2'd0;

  function automatic sat2_t sat_step(input sat2_t cur, input logic taken);
    sat2_t nxt;
    if (taken) nxt = (cur == SAT_MAX) ? cur : cur + 2'd1;
    else       nxt = (cur == SAT_MIN) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic sat_dir(input sat2_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [N-1:0] hist
);
  logic [N-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[N-2:0], shift_bit};
  end

  assign hist = hist_q;

  p_hist_shift_r6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q == {$past(hist_q[N-2:0]), $past(shift_bit)}));

  p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !$past(rst)) |=> $stable(hist_q));
endmodule

// File: rtl/bp_index_hash.sv
module bp_index_hash #(
  parameter int N    = 10,
  parameter int PC_W = 32
) (
  input  logic [N-1:0]    hist,
  input  logic [PC_W-1:0] pc,
  output logic [N-1:0]    idx
);
  localparam int LO = 2;
  localparam int HI = N + 1;

  assign idx = hist ^ pc[HI:LO];

  generate
    if (PC_W > HI + 1) begin : g_upper
      logic unused_pc_bits;
      assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};
    end else begin : g_exact
      logic unused_pc_bits;
      assign unused_pc_bits = ^pc[LO-1:0];
    end
  endgenerate
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import gshare_pkg::*;
#(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rd_idx,
  output sat2_t        rd_cnt,
  input  logic         wr_en,
  input  logic [N-1:0] wr_idx,
  input  logic         wr_taken
);
  localparam int DEPTH = 1 << N;

  sat2_t cnt_q [DEPTH];
  sat2_t wr_cur;

  assign wr_cur = cnt_q[wr_idx];
  assign rd_cnt = cnt_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= SAT_RESET;
    end else if (wr_en) begin
      cnt_q[wr_idx] <= sat_step(wr_cur, wr_taken);
    end
  end

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur != SAT_MAX) |=>
      (cnt_q[$past(wr_idx)] == $past(wr_cur) + 2'd1));

  p_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur == SAT_MAX) |=>
      (cnt_q[$past(wr_idx)] == SAT_MAX));

  p_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur != SAT_MIN) |=>
      (cnt_q[$past(wr_idx)] == $past(wr_cur) - 2'd1));

  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur == SAT_MIN) |=>
      (cnt_q[$past(wr_idx)] == SAT_MIN));
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_LEN = 10,
  parameter int PC_W     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PC_W-1:0]     pred_pc,
  output logic                pred_taken,
  output logic [HIST_LEN-1:0] pred_index,
  input  logic                upd_valid,
  input  logic [HIST_LEN-1:0] upd_index,
  input  logic                upd_taken
);
  logic [HIST_LEN-1:0] hist;
  logic [HIST_LEN-1:0] lookup_idx;
  sat2_t               lookup_cnt;

  bp_history #(.N(HIST_LEN)) i_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (hist)
  );

  bp_index_hash #(.N(HIST_LEN), .PC_W(PC_W)) i_hash (
    .hist (hist),
    .pc   (pred_pc),
    .idx  (lookup_idx)
  );

  bp_counter_table #(.N(HIST_LEN)) i_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lookup_idx),
    .rd_cnt   (lookup_cnt),
    .wr_en    (upd_valid),
    .wr_idx   (upd_index),
    .wr_taken (upd_taken)
  );

  assign pred_index = lookup_idx;
  assign pred_taken = sat_dir(lookup_cnt);

  p_reset_cold_r1: assert property (@(posedge clk)
    $past(rst) |-> (hist == '0));
endmodule

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;
  localparam int N    = 4;
  localparam int PC_W = 16;
  localparam int DEP  = 1 << N;
  localparam int MSK  = DEP - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken;
  logic [N-1:0]    pred_index;
  logic            upd_valid = 1'b0;
  logic [N-1:0]    upd_index = '0;
  logic            upd_taken = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int m_cnt [DEP];
  int m_hist = 0;
  int lf = 16'hACE1;

  always #5 clk = ~clk;

  gshare_predictor #(.HIST_LEN(N), .PC_W(PC_W)) i_gshare_predictor (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_index(pred_index), .upd_valid(upd_valid), .upd_index(upd_index),
    .upd_taken(upd_taken)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lf_step();
    if ((lf & 1) != 0) lf = (lf >> 1) ^ 16'hB400;
    else lf = lf >> 1;
  endtask

  function automatic int pc_for(int idx, int junk);
    return ((junk & 16'hFFC0) | ((((idx ^ m_hist) & MSK)) << 2) | (junk & 3)) & 16'hFFFF;
  endfunction

  task automatic model_upd(input int idx, input bit t);
    if (t) m_cnt[idx] = (m_cnt[idx] == 3) ? 3 : m_cnt[idx] + 1;
    else   m_cnt[idx] = (m_cnt[idx] == 0) ? 0 : m_cnt[idx] - 1;
    m_hist = ((m_hist << 1) | int'(t)) & MSK;
  endtask

  task automatic apply_update(input int idx, input bit t);
    upd_valid = 1'b1;
    upd_index = N'(idx);
    upd_taken = t;
    @(posedge clk); #1;
    upd_valid = 1'b0;
    model_upd(idx, t);
    @(negedge clk);
  endtask

  task automatic probe(input string req, input int idx);
    lf_step();
    pred_pc = PC_W'(pc_for(idx, lf));
    #1;
    chk(req, int'(pred_taken), int'(m_cnt[idx] >= 2));
    chk(req, int'(pred_index), idx);
  endtask

  task automatic sweep_all(input string req);
    for (int i = 0; i < DEP; i++) probe(req, i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEP; i++) m_cnt[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: all counters weakly not-taken, history zero
    for (int i = 0; i < DEP; i++) begin
      pred_pc = PC_W'((i << 2) | 16'hA403);
      #1;
      chk("R1 reset direction", int'(pred_taken), 0);
      chk("R1 reset index", int'(pred_index), i);
    end
    // R2 R5 R6 R9: pseudo-random training against the model
    for (int it = 0; it < 240; it++) begin
      int exp_i;
      lf_step();
      pred_pc = PC_W'(lf);
      #1;
      exp_i = (m_hist ^ (lf >> 2)) & MSK;
      chk("R2 hashed index", int'(pred_index), exp_i);
      chk("R5 direction", int'(pred_taken), int'(m_cnt[exp_i] >= 2));
      lf_step();
      // R6: outcome shifted into history, reflected by later indices
      apply_update(exp_i, ((lf & 3) != 0) ^ ((exp_i & 1) != 0));
      if (it % 40 == 39) sweep_all("R9 table sweep");
    end
    // R3: saturate high, one decrement still predicts taken
    for (int k = 0; k < 5; k++) apply_update(6, 1'b1);
    probe("R3 saturated high", 6);
    apply_update(6, 1'b0);
    probe("R3 no wrap after ceiling", 6);
    chk("R3 model at 2", m_cnt[6], 2);
    // R4: saturate low, one increment still predicts not-taken
    for (int k = 0; k < 5; k++) apply_update(9, 1'b0);
    probe("R4 saturated low", 9);
    apply_update(9, 1'b1);
    probe("R4 no wrap after floor", 9);
    chk("R4 model at 1", m_cnt[9], 1);
    // R7: same-entry lookup and update in one cycle
    apply_update(9, 1'b1);
    pred_pc = PC_W'(pc_for(9, 16'h1234));
    upd_valid = 1'b1;
    upd_index = N'(9);
    upd_taken = 1'b0;
    #1;
    chk("R7 pre-update value", int'(pred_taken), 1);
    chk("R7 collision index", int'(pred_index), 9);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    model_upd(9, 1'b0);
    @(negedge clk);
    probe("R7 post-update value", 9);
    // R8: idle update inputs have no effect
    for (int k = 0; k < 6; k++) begin
      upd_index = N'(k * 5);
      upd_taken = k[0];
      @(negedge clk);
    end
    sweep_all("R8 idle update ignored");
    finish_run();
  end
endmodule